// File: doc/BRIEF.md
# One-Time-Programmable Word Memory Slave Programming Controller

This block lets an external programmer write and read back a one-time-programmable (OTP) word memory through a 16-bit open-drain bus and three active-low strobes. These are an address-latch strobe, a program/dump strobe and an auto-increment request. Every strobe is asynchronous to the block clock. Each passes through a two-flop synchronizer, and the block acts on the edges it sees in its own clock domain.

The programmer runs each operation in three steps. It sends a command word on one address-strobe fall and an address on the next. It then pulses the program/dump strobe once per word. In program mode, the block latches the bus word, issues a write pulse to the memory and reads the location back. It keeps repeating the write and the read-back while the strobe stays low. In dump mode, it reads the location and pulls the bus low wherever the word holds a 0, until the strobe rises. At the end of each word, holding auto-increment low moves to the next address in the same mode. Otherwise the block returns to waiting for a command.

Two status flags report the result. One flag gives the result of the last read-back. The other is a sticky flag that drops on the first mismatch.

The memory port is a valid/ready request channel with a response strobe:
- The block raises a request and holds it stable (valid, write flag, address and data) until the memory accepts it with ready.
- The block has at most one read outstanding.
- The memory returns exactly one response pulse per accepted read, in a later cycle.
- Writes have no response.
- The block accepts a response in any cycle and offers no back-pressure on it.

Top module: `otp_slave_prog`

## Requirements
- R1: After reset, both status flags are 1, the bus is released (all pull enables 0), no memory request is raised, and the block waits for a command word.
- R2: The first address-strobe fall captures a command word: 16'h00A1 selects program mode and 16'h00D1 selects dump mode. Any other value is ignored, so no memory write follows. After a valid command, the next address-strobe fall captures the address from the low AW bus bits.
- R3: In program mode, a program-strobe fall latches the bus word. The block then issues a write of that word to the current address, and afterwards a read of the same address.
- R4: While the program strobe stays low, the write/read-back cycle repeats on the same location with the same latched word. Holding the strobe for many cycles yields two or more writes.
- R5: The per-word flag updates after each read-back. It is 1 when the read word equals the latched word and 0 otherwise. A 1 written over a 0 already cleared in the memory therefore reads back as an error.
- R6: The cumulative flag is 1 while every read-back so far has matched. After the first mismatch it stays 0 until reset.
- R7: In dump mode, a program-strobe fall reads the current address. The block then pulls low each bus bit that is 0 in the word until the strobe rises, and then releases the bus.
- R8: The bus is only ever pulled low or released. A pull enable is set only while a dumped word is being driven.
- R9: After the program strobe rises, the block samples auto-increment. If it is low, the address increments, wrapping from 2^AW-1 to 0, and the block waits for the next strobe fall in the same mode. If it is high, the block returns to waiting for a command, and later program-strobe falls cause no memory access.
- R10: A memory request holds its valid, write flag, address and data stable until ready is seen high.
- R11: An address-strobe fall while the block waits for a program-strobe fall is decoded as a new command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_strobe_n | input | 1 | Command/address latch strobe, acts on its fall |
| prog_strobe_n | input | 1 | Program/dump strobe, active low |
| auto_inc_n | input | 1 | Auto-increment request, active low |
| bus_i | input | DW | Sampled level of the shared open-drain bus |
| bus_pull_o | output | DW | Per-bit pull-low enables for the bus |
| word_ok_o | output | 1 | Result of the last read-back comparison |
| all_ok_o | output | 1 | Sticky cumulative verify flag |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_write_o | output | 1 | 1 = program pulse, 0 = read |
| mem_req_addr_o | output | AW | Memory word address |
| mem_req_wdata_o | output | DW | Word to program |
| mem_rsp_valid_i | input | 1 | Read data valid, one pulse per read |
| mem_rsp_rdata_i | input | DW | Read data |

## Verification
The assertions assume the memory follows the channel rules. That means exactly one response per accepted read, never one without a read pending, and no response to writes. The bench memory model answers two cycles after accepting a read, and stalls ready in a fixed one-in-three pattern so that held requests occur.

The assertions also assume the programmer keeps the bus word stable around each strobe fall and holds every strobe level for several clock cycles. The bench sets the bus two cycles before each fall, keeps it until well after the strobe returns high, and holds each strobe for at least six cycles.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam logic [15:0] CMD_PROGRAM = 16'h00A1;
  localparam logic [15:0] CMD_DUMP    = 16'h00D1;

  typedef enum logic [3:0] {
    S_CMD, S_ADDR,
    S_PWAIT, S_PWR, S_PHOLD, S_PRD, S_PCMP,
    S_DWAIT, S_DRD, S_DRSP, S_DDRV
  } otp_state_e;
endpackage

// File: rtl/otp_strobe_sync.sv
module otp_strobe_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
        s3 <= 1'b1;
      end else begin
        s1 <= async_i[g];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign lvl_o[g]  = s2;
    assign fall_o[g] = s3 & ~s2;
  end
endmodule

// File: rtl/otp_verify_flags.sv
module otp_verify_flags #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_i,
  input  logic [DW-1:0] got_i,
  input  logic [DW-1:0] exp_i,
  output logic          word_ok_o,
  output logic          all_ok_o
);
  logic match;
  assign match = (got_i == exp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_ok_o <= 1'b1;
      all_ok_o  <= 1'b1;
    end else if (chk_i) begin
      word_ok_o <= match;
      all_ok_o  <= all_ok_o & match;
    end
  end
endmodule

// File: rtl/otp_od_driver.sv
module otp_od_driver #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          release_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] pull_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pull_o <= '0;
    else if (release_i) pull_o <= '0;
    else if (load_i)    pull_o <= ~word_i;
  end
endmodule

// File: rtl/otp_slave_prog.sv
module otp_slave_prog
  import otp_pkg::*;
#(
  parameter int AW        = 10,
  parameter int DW        = 16,
  parameter int PULSE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_strobe_n,
  input  logic          prog_strobe_n,
  input  logic          auto_inc_n,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_pull_o,
  output logic          word_ok_o,
  output logic          all_ok_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_write_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [DW-1:0] mem_req_wdata_o,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rsp_rdata_i
);
  localparam int NSTB = 3;
  localparam int CW   = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

  logic [NSTB-1:0] stb_lvl, stb_fall;
  otp_strobe_sync #(.N(NSTB)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({auto_inc_n, prog_strobe_n, addr_strobe_n}),
    .lvl_o  (stb_lvl),
    .fall_o (stb_fall)
  );

  logic ale_fall, prog_fall, prog_high, inc_req;
  assign ale_fall  = stb_fall[0];
  assign prog_fall = stb_fall[1];
  assign prog_high = stb_lvl[1];
  assign inc_req   = ~stb_lvl[2];

  otp_state_e      st;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;
  logic [CW-1:0]   pulse_cnt;

  logic is_prog_cmd, is_dump_cmd;
  assign is_prog_cmd = (bus_i == DW'(CMD_PROGRAM));
  assign is_dump_cmd = (bus_i == DW'(CMD_DUMP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_CMD;
      addr_q    <= '0;
      data_q    <= '0;
      pulse_cnt <= '0;
    end else begin
      case (st)
        S_CMD, S_PWAIT, S_DWAIT: begin
          if (ale_fall) begin
            if (is_prog_cmd || is_dump_cmd) st <= S_ADDR;
            else                            st <= S_CMD;
            if (is_prog_cmd) data_q <= '0;
            pulse_cnt <= CW'(is_prog_cmd);
          end else if (st == S_PWAIT && prog_fall) begin
            data_q <= bus_i;
            st     <= S_PWR;
          end else if (st == S_DWAIT && prog_fall) begin
            st <= S_DRD;
          end
        end
        S_ADDR: begin
          if (ale_fall) begin
            addr_q <= bus_i[AW-1:0];
            st     <= (pulse_cnt != '0) ? S_PWAIT : S_DWAIT;
          end
        end
        S_PWR: begin
          if (mem_req_ready_i) begin
            pulse_cnt <= '0;
            st        <= S_PHOLD;
          end
        end
        S_PHOLD: begin
          if (pulse_cnt == CW'(PULSE_CYC - 1)) st <= S_PRD;
          else pulse_cnt <= pulse_cnt + 1'b1;
        end
        S_PRD: if (mem_req_ready_i) st <= S_PCMP;
        S_PCMP: begin
          if (mem_rsp_valid_i) begin
            if (!prog_high) begin
              st <= S_PWR;
            end else if (inc_req) begin
              addr_q    <= addr_q + 1'b1;
              pulse_cnt <= CW'(1);
              st        <= S_PWAIT;
            end else begin
              st <= S_CMD;
            end
          end
        end
        S_DRD:  if (mem_req_ready_i) st <= S_DRSP;
        S_DRSP: if (mem_rsp_valid_i) st <= S_DDRV;
        S_DDRV: begin
          if (prog_high) begin
            if (inc_req) begin
              addr_q    <= addr_q + 1'b1;
              pulse_cnt <= '0;
              st        <= S_DWAIT;
            end else begin
              st <= S_CMD;
            end
          end
        end
        default: st <= S_CMD;
      endcase
    end
  end

  assign mem_req_valid_o = (st == S_PWR) || (st == S_PRD) || (st == S_DRD);
  assign mem_req_write_o = (st == S_PWR);
  assign mem_req_addr_o  = addr_q;
  assign mem_req_wdata_o = data_q;

  otp_verify_flags #(.DW(DW)) u_verify (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_i    ((st == S_PCMP) && mem_rsp_valid_i),
    .got_i    (mem_rsp_rdata_i),
    .exp_i    (data_q),
    .word_ok_o(word_ok_o),
    .all_ok_o (all_ok_o)
  );

  otp_od_driver #(.DW(DW)) u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   ((st == S_DRSP) && mem_rsp_valid_i),
    .release_i((st == S_DDRV) && prog_high),
    .word_i   (mem_rsp_rdata_i),
    .pull_o   (bus_pull_o)
  );
endmodule

// File: rtl/otp_slave_prog_chk.sv
module otp_slave_prog_chk #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] bus_pull_o,
  input logic          drive_phase,
  input logic          word_ok_o,
  input logic          all_ok_o,
  input logic          mem_req_valid_o,
  input logic          mem_req_ready_i,
  input logic          mem_req_write_o,
  input logic [AW-1:0] mem_req_addr_o,
  input logic [DW-1:0] mem_req_wdata_o,
  input logic          mem_rsp_valid_i
);
  // R8: pull enables only while a dumped word is driven
  a_r8_pull_only_in_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_pull_o) |-> drive_phase);

  // R6: cumulative flag never recovers
  a_r6_all_ok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !all_ok_o |=> !all_ok_o);

  // R6: cumulative flag drops only together with a failed word
  a_r6_fall_with_bad_word: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(all_ok_o) |-> !word_ok_o);

  // R5: per-word flag moves only after a read response
  a_r5_word_ok_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_ok_o) |-> $past(mem_rsp_valid_i));

  // R10: stalled request held stable
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_write_o) &&
       $stable(mem_req_addr_o) && $stable(mem_req_wdata_o)));
endmodule

bind otp_slave_prog otp_slave_prog_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_pull_o     (bus_pull_o),
  .drive_phase    (st == otp_pkg::S_DDRV),
  .word_ok_o      (word_ok_o),
  .all_ok_o       (all_ok_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_write_o(mem_req_write_o),
  .mem_req_addr_o (mem_req_addr_o),
  .mem_req_wdata_o(mem_req_wdata_o),
  .mem_rsp_valid_i(mem_rsp_valid_i)
);

// File: tb/test_otp_slave_prog.sv
module test_otp_slave_prog;
  localparam int CLK_P = 10;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam logic [15:0] C_PROG = 16'h00A1;
  localparam logic [15:0] C_DUMP = 16'h00D1;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n = 1'b0;
  logic ale_n = 1'b1, prog_n = 1'b1, ainc_n = 1'b1;
  logic [DW-1:0] host_word = '1;
  logic [DW-1:0] bus, pull;
  logic word_ok, all_ok;
  logic req_v, req_w, rdy, rsp_v;
  logic [AW-1:0] req_a;
  logic [DW-1:0] req_d, rsp_d;

  assign bus = host_word & ~pull;

  otp_slave_prog #(.AW(AW), .DW(DW), .PULSE_CYC(4)) i_otp_slave_prog (
    .clk(clk), .rst_n(rst_n),
    .addr_strobe_n(ale_n), .prog_strobe_n(prog_n), .auto_inc_n(ainc_n),
    .bus_i(bus), .bus_pull_o(pull),
    .word_ok_o(word_ok), .all_ok_o(all_ok),
    .mem_req_valid_o(req_v), .mem_req_ready_i(rdy), .mem_req_write_o(req_w),
    .mem_req_addr_o(req_a), .mem_req_wdata_o(req_d),
    .mem_rsp_valid_i(rsp_v), .mem_rsp_rdata_i(rsp_d)
  );

  // OTP memory model: erased to all ones, programming can only clear bits
  logic [DW-1:0] mem [1<<AW];
  logic [7:0] cyc;
  logic p1, p2;
  logic [DW-1:0] d1, d2;
  int nwr, nrd;
  assign rdy   = (cyc % 3) != 2;
  assign rsp_v = p2;
  assign rsp_d = d2;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<AW); i++) mem[i] <= '1;
      cyc <= '0; p1 <= 1'b0; p2 <= 1'b0; d1 <= '0; d2 <= '0;
      nwr <= 0; nrd <= 0;
    end else begin
      cyc <= cyc + 1'b1;
      p2 <= p1; d2 <= d1; p1 <= 1'b0;
      if (req_v && rdy) begin
        if (req_w) begin
          mem[req_a] <= mem[req_a] & req_d;
          nwr <= nwr + 1;
        end else begin
          p1 <= 1'b1; d1 <= mem[req_a];
          nrd <= nrd + 1;
        end
      end
    end
  end

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_word(input logic [15:0] w);
    host_word = w; wait_n(2);
    ale_n = 1'b0; wait_n(6);
    ale_n = 1'b1; wait_n(3);
    host_word = '1;
  endtask

  task automatic prog_word(input logic [15:0] w, input int hold, input bit inc);
    host_word = w; ainc_n = ~inc; wait_n(2);
    prog_n = 1'b0; wait_n(hold);
    prog_n = 1'b1; wait_n(30);
    host_word = '1; ainc_n = 1'b1; wait_n(2);
  endtask

  task automatic dump_word(input bit inc, output logic [15:0] got, output logic [15:0] pull_after);
    host_word = '1; ainc_n = ~inc; wait_n(2);
    prog_n = 1'b0; wait_n(20);
    got = bus;
    prog_n = 1'b1; wait_n(30);
    pull_after = pull; ainc_n = 1'b1; wait_n(2);
  endtask

  task automatic t_reset;
    chk(word_ok == 1'b1, "R1 word flag", 32'(word_ok), 1);
    chk(all_ok == 1'b1, "R1 sticky flag", 32'(all_ok), 1);
    chk(pull == '0, "R1 bus released", 32'(pull), 0);
    chk(req_v == 1'b0, "R1 no request", 32'(req_v), 0);
  endtask

  task automatic t_program_dump;
    logic [15:0] g, pa;
    int w0;
    w0 = nwr;
    strobe_word(C_PROG); strobe_word(16'h0005);
    prog_word(16'h1234, 6, 1'b0);
    chk(nwr == w0 + 1, "R3 one write", 32'(nwr - w0), 1);
    chk(word_ok == 1'b1, "R5 word ok", 32'(word_ok), 1);
    strobe_word(C_DUMP); strobe_word(16'h0005);
    dump_word(1'b0, g, pa);
    chk(g == 16'h1234, "R7 dumped word", 32'(g), 32'h1234);
    chk(pa == '0, "R7 R8 bus released after dump", 32'(pa), 0);
  endtask

  task automatic t_unknown_cmd;
    int w0, r0;
    w0 = nwr; r0 = nrd;
    strobe_word(16'h0000); strobe_word(16'h0033);
    prog_word(16'hAAAA, 6, 1'b0);
    chk(nwr == w0 && nrd == r0, "R2 unknown command ignored", 32'(nwr - w0 + nrd - r0), 0);
    chk(pull == '0, "R8 no drive", 32'(pull), 0);
  endtask

  task automatic t_stream;
    logic [15:0] g, pa;
    int w0;
    strobe_word(C_PROG); strobe_word(16'h0010);
    prog_word(16'h1111, 6, 1'b1);
    prog_word(16'h2222, 6, 1'b1);
    prog_word(16'h3333, 6, 1'b0);
    w0 = nwr;
    prog_word(16'h4444, 6, 1'b0);
    chk(nwr == w0, "R9 strobe ignored after end", 32'(nwr - w0), 0);
    strobe_word(C_DUMP); strobe_word(16'h0010);
    dump_word(1'b1, g, pa); chk(g == 16'h1111, "R9 stream word0", 32'(g), 32'h1111);
    dump_word(1'b1, g, pa); chk(g == 16'h2222, "R9 stream word1", 32'(g), 32'h2222);
    dump_word(1'b0, g, pa); chk(g == 16'h3333, "R9 stream word2", 32'(g), 32'h3333);
  endtask

  task automatic t_wrap;
    logic [15:0] g, pa;
    strobe_word(C_PROG); strobe_word(16'h03FF);
    prog_word(16'h0F0F, 6, 1'b1);
    prog_word(16'h00F0, 6, 1'b0);
    strobe_word(C_DUMP); strobe_word(16'h0000);
    dump_word(1'b0, g, pa);
    chk(g == 16'h00F0, "R9 address wraps to 0", 32'(g), 32'h00F0);
    strobe_word(C_DUMP); strobe_word(16'h03FF);
    dump_word(1'b0, g, pa);
    chk(g == 16'h0F0F, "R9 last address", 32'(g), 32'h0F0F);
  endtask

  task automatic t_hold_repeat;
    int w0;
    w0 = nwr;
    strobe_word(C_PROG); strobe_word(16'h0040);
    prog_word(16'h5A5A, 80, 1'b0);
    // R10: ready stalls one cycle in three during these requests
    chk(nwr - w0 >= 2, "R4 R10 repeated pulses", 32'(nwr - w0), 2);
    chk(word_ok == 1'b1, "R5 repeated word ok", 32'(word_ok), 1);
  endtask

  task automatic t_restart;
    logic [15:0] g, pa;
    int w0;
    w0 = nwr;
    strobe_word(C_PROG); strobe_word(16'h0050);
    strobe_word(C_DUMP); strobe_word(16'h0011);
    dump_word(1'b0, g, pa);
    chk(g == 16'h2222, "R11 new command while waiting", 32'(g), 32'h2222);
    chk(nwr == w0, "R11 no write", 32'(nwr - w0), 0);
  endtask

  task automatic t_fail_sticky;
    strobe_word(C_PROG); strobe_word(16'h0005);
    prog_word(16'hFFFF, 6, 1'b0);
    chk(word_ok == 1'b0, "R5 one over cleared zero fails", 32'(word_ok), 0);
    chk(all_ok == 1'b0, "R6 sticky drops", 32'(all_ok), 0);
    strobe_word(C_PROG); strobe_word(16'h0060);
    prog_word(16'h00FF, 6, 1'b0);
    chk(word_ok == 1'b1, "R5 good word after failure", 32'(word_ok), 1);
    chk(all_ok == 1'b0, "R6 sticky stays low", 32'(all_ok), 0);
  endtask

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    t_reset();
    t_program_dump();
    t_unknown_cmd();
    t_stream();
    t_wrap();
    t_hold_repeat();
    t_restart();
    t_fail_sticky();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule